// File: doc/BRIEF.md
# Saturating Fixed-Point FIR Filter

This block is a sixteen-tap direct-form FIR filter for signed fixed-point samples. Each time the input strobe is high, the block takes one 16-bit sample. It multiplies that sample, together with the fifteen earlier samples it has stored, by a fixed symmetric set of integer coefficients. The sum is formed at full width and then scaled back to the port format. The scaling shifts out the fractional bits with round-half-up. If the result lies outside the 16-bit signed range, it is clamped to the nearest limit and never wraps.

Each accepted sample gives exactly one output, registered one cycle later. The stored history advances only when a sample is accepted, so the gaps between strobes do not change the filter's state. The coefficients are built into the block and are not reloaded at run time.

Top module: `fir_sat_top`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_data is 0. Every history slot is cleared to zero, so the first sample after reset is filtered against an all-zero past.
- R2: out_valid is high in the cycle after in_valid was sampled high, and low in the cycle after in_valid was sampled low.
- R3: The wide sum for an accepted sample x is x*c[15] + sum over i=1..15 of h[i]*c[15-i]. Here h[i] is the sample accepted i strobes earlier. The coefficients are c[0..7] = 98, -39, -327, 439, 950, -2097, -1674, 9883 and c[15-k] = c[k].
- R4: The history moves by one slot only on an accepted sample, after the output for that sample has been formed. The newest sample goes into slot 1. Cycles with in_valid low leave the history unchanged.
- R5: The sum is divided by 2^12 (default fraction width 12) with round-half-up. Half an LSB is added before an arithmetic shift, so 1024*98 gives 25 and -1024*98 gives -24.
- R6: A rounded result above 32767 gives out_data = 0x7FFF.
- R7: A rounded result below -32768 gives out_data = 0x8000.
- R8: out_data keeps its last value in every cycle that follows a cycle with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe; in_data is accepted on this edge |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new filtered result |
| out_data | output | 16 | Rounded and saturated signed result |

## Verification
The assertions assume that in_valid and in_data are driven to known values whenever reset is released. They also assume that a sample exists only on the edge where in_valid is high, with no notion of backpressure. The stimulus changes inputs only on the falling edge and drops in_valid to 0 between strobes. It inserts idle gaps of zero, one and two cycles, so that the checks on history hold and on output hold see both back-to-back and spaced samples. The saturation checks rely on the full-scale values 32767 and -32768 reaching the centre tap.

// File: rtl/fir_sat_pkg.sv
package fir_sat_pkg;

   // Symmetric integer coefficient set; entry idx of a taps-long table.
   function automatic int signed tap_coef(input int unsigned idx, input int unsigned taps);
      int unsigned m;
      m = (idx < taps / 2) ? idx : (taps - 1 - idx);
      case (m)
         0:       tap_coef = 98;
         1:       tap_coef = -39;
         2:       tap_coef = -327;
         3:       tap_coef = 439;
         4:       tap_coef = 950;
         5:       tap_coef = -2097;
         6:       tap_coef = -1674;
         default: tap_coef = 9883;
      endcase
   endfunction

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 15
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      shift_en,
   input  logic [DATA_W-1:0]         din,
   output logic [DEPTH*DATA_W-1:0]   hist_flat
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        slot_q[k] <= '0;
            else if (shift_en) slot_q[k] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        slot_q[k] <= '0;
            else if (shift_en) slot_q[k] <= slot_q[k-1];
         end
      end
      assign hist_flat[k*DATA_W +: DATA_W] = slot_q[k];
   end

endmodule

// File: rtl/fir_mac.sv
module fir_mac
   import fir_sat_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned COEF_W   = 16,
   parameter int unsigned TAPS     = 16,
   parameter int unsigned ACC_W    = 36,
   parameter bit          ADD_TREE = 1'b1
) (
   input  logic signed [DATA_W-1:0]          cur,
   input  logic [(TAPS-1)*DATA_W-1:0]        hist_flat,
   output logic signed [ACC_W-1:0]           acc
);

   localparam int unsigned LVLS = $clog2(TAPS);

   logic signed [ACC_W-1:0] prod [TAPS];

   // Term k pairs the sample k strobes old with coefficient TAPS-1-k.
   for (genvar k = 0; k < TAPS; k++) begin : g_prod
      localparam logic signed [COEF_W-1:0] CK = COEF_W'(tap_coef(TAPS - 1 - k, TAPS));
      logic signed [DATA_W-1:0] smp;
      if (k == 0) begin : g_now
         assign smp = cur;
      end else begin : g_old
         assign smp = hist_flat[(k-1)*DATA_W +: DATA_W];
      end
      assign prod[k] = ACC_W'(smp) * ACC_W'(CK);
   end

   if (ADD_TREE) begin : g_tree
      for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
         logic signed [ACC_W-1:0] part [TAPS >> l];
         for (genvar i = 0; i < (TAPS >> l); i++) begin : g_n
            if (l == 0) begin : g_leaf
               assign part[i] = prod[i];
            end else begin : g_add
               assign part[i] = g_lvl[l-1].part[2*i] + g_lvl[l-1].part[2*i+1];
            end
         end
      end
      assign acc = g_lvl[LVLS].part[0];
   end else begin : g_chain
      always_comb begin
         acc = '0;
         for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
      end
   end

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
   parameter int unsigned ACC_W  = 36,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned FRAC_W = 12
) (
   input  logic signed [ACC_W-1:0]  acc,
   output logic signed [DATA_W-1:0] dout
);

   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] scaled;

   assign biased = acc + HALF;
   assign scaled = biased >>> FRAC_W;

   always_comb begin
      if (scaled > MAXV)      dout = {1'b0, {(DATA_W-1){1'b1}}};
      else if (scaled < MINV) dout = {1'b1, {(DATA_W-1){1'b0}}};
      else                    dout = scaled[DATA_W-1:0];
   end

endmodule

// File: rtl/fir_sat_top.sv
module fir_sat_top #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned COEF_W   = 16,
   parameter int unsigned TAPS     = 16,
   parameter int unsigned FRAC_W   = 12,
   parameter int unsigned GUARD_W  = 4,
   parameter bit          ADD_TREE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);

   localparam int unsigned ACC_W  = DATA_W + COEF_W + GUARD_W;
   localparam int unsigned HIST_N = TAPS - 1;
   localparam int unsigned HIST_W = HIST_N * DATA_W;

   if (TAPS != 16) begin : g_bad_taps
      $error("fir_sat_top: coefficient set is defined for 16 taps only");
   end
   if (GUARD_W < $clog2(TAPS)) begin : g_bad_guard
      $error("fir_sat_top: GUARD_W too small for the tap count");
   end
   if (COEF_W < 15) begin : g_bad_coef
      $error("fir_sat_top: COEF_W cannot hold the largest coefficient");
   end
   if (FRAC_W < 1 || FRAC_W >= ACC_W - DATA_W) begin : g_bad_frac
      $error("fir_sat_top: FRAC_W out of range");
   end

   logic [HIST_W-1:0]        hist_flat;
   logic signed [ACC_W-1:0]  acc_sum;
   logic signed [DATA_W-1:0] result;

   fir_delay_line #(
      .DATA_W (DATA_W),
      .DEPTH  (HIST_N)
   ) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (in_valid),
      .din       (in_data),
      .hist_flat (hist_flat)
   );

   fir_mac #(
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W),
      .TAPS     (TAPS),
      .ACC_W    (ACC_W),
      .ADD_TREE (ADD_TREE)
   ) u_mac (
      .cur       (in_data),
      .hist_flat (hist_flat),
      .acc       (acc_sum)
   );

   fir_round_sat #(
      .ACC_W  (ACC_W),
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W)
   ) u_rsat (
      .acc  (acc_sum),
      .dout (result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end

endmodule

// File: rtl/fir_sat_chk.sv
module fir_sat_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned FRAC_W = 12,
   parameter int unsigned ACC_W  = 36,
   parameter int unsigned HIST_W = 240
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data,
   input logic signed [ACC_W-1:0]  acc,
   input logic [HIST_W-1:0]        hist_flat
);

   localparam longint SCALE = longint'(1) <<< FRAC_W;
   localparam longint HALFL = longint'(1) <<< (FRAC_W - 1);
   localparam longint TOPV  = (longint'(1) <<< (DATA_W - 1)) - 1;
   localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(TOPV * SCALE + HALFL);
   localparam logic signed [ACC_W-1:0] NEG_LIM = ACC_W'(-(TOPV + 1) * SCALE - HALFL);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_data == '0)); // R1

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2

   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2

   AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(hist_flat)); // R4

   AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc >= POS_LIM) |=> out_data == {1'b0, {(DATA_W-1){1'b1}}}); // R6

   AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc < NEG_LIM) |=> out_data == {1'b1, {(DATA_W-1){1'b0}}}); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R8

endmodule

bind fir_sat_top fir_sat_chk #(
   .DATA_W (DATA_W),
   .FRAC_W (FRAC_W),
   .ACC_W  (ACC_W),
   .HIST_W (HIST_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data),
   .acc       (acc_sum),
   .hist_flat (hist_flat)
);

// File: tb/test_fir_sat_top.sv
module test_fir_sat_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 32;

   typedef struct packed {
      logic signed [15:0] din;
      logic signed [15:0] dout;
   } vec_t;

   // First 16: impulse of 1.0 (4096) then zeros -> coefficients in order (R3).
   // Last 16: constant 4096 -> running sums of the coefficients (R3).
   localparam vec_t VEC [NVEC] = '{
      '{16'sd4096, 16'sd98},    '{16'sd0, -16'sd39},     '{16'sd0, -16'sd327},   '{16'sd0, 16'sd439},
      '{16'sd0, 16'sd950},      '{16'sd0, -16'sd2097},   '{16'sd0, -16'sd1674},  '{16'sd0, 16'sd9883},
      '{16'sd0, 16'sd9883},     '{16'sd0, -16'sd1674},   '{16'sd0, -16'sd2097},  '{16'sd0, 16'sd950},
      '{16'sd0, 16'sd439},      '{16'sd0, -16'sd327},    '{16'sd0, -16'sd39},    '{16'sd0, 16'sd98},
      '{16'sd4096, 16'sd98},    '{16'sd4096, 16'sd59},   '{16'sd4096, -16'sd268},'{16'sd4096, 16'sd171},
      '{16'sd4096, 16'sd1121},  '{16'sd4096, -16'sd976}, '{16'sd4096, -16'sd2650},'{16'sd4096, 16'sd7233},
      '{16'sd4096, 16'sd17116}, '{16'sd4096, 16'sd15442},'{16'sd4096, 16'sd13345},'{16'sd4096, 16'sd14295},
      '{16'sd4096, 16'sd14734}, '{16'sd4096, 16'sd14407},'{16'sd4096, 16'sd14368},'{16'sd4096, 16'sd14466}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               out_valid;
   logic signed [15:0] out_data;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fir_sat_top i_fir_sat_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      @(negedge clk);
      @(negedge clk);
      check("R1 out_valid in reset", int'(out_valid), 0);
      check("R1 out_data in reset", int'(out_data), 0);
      rst_n = 1'b1;
   endtask

   // Called at a falling edge; returns at the next falling edge with in_valid low.
   task automatic send(input logic signed [15:0] x, input bit chk, input string req,
                       input int exp);
      in_valid = 1'b1;
      in_data  = x;
      @(negedge clk);
      if (chk) begin
         check({req, " out_valid"}, int'(out_valid), 1);
         check(req, int'(out_data), exp);
      end
      in_valid = 1'b0;
      in_data  = '0;
   endtask

   task automatic idle(input int held);
      @(negedge clk);
      check("R2 out_valid low after idle", int'(out_valid), 0);
      check("R8 out_data held", int'(out_data), held);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 out_valid at reset", int'(out_valid), 0);
      check("R1 out_data at reset", int'(out_data), 0);
      rst_n = 1'b1;

      // Table walk with 0/1/2 idle cycles between samples (R3, R4 with gaps, R2, R8).
      for (int i = 0; i < NVEC; i++) begin
         send(VEC[i].din, 1'b1, "R3/R4 table", int'(VEC[i].dout));
         for (int g = 0; g < i % 3; g++) idle(int'(VEC[i].dout));
      end

      // R5: round-half-up on both signs.
      do_reset();
      send(16'sd1024, 1'b1, "R5 half rounds up (positive)", 25);
      do_reset();
      send(-16'sd1024, 1'b1, "R5 half rounds up (negative)", -24);

      // R6: full-scale positive reaches the centre tap.
      do_reset();
      send(16'sd32767, 1'b0, "", 0);
      for (int k = 0; k < 6; k++) send(16'sd0, 1'b0, "", 0);
      send(16'sd0, 1'b1, "R6 clamp to 0x7FFF", 32767);

      // R7: full-scale negative reaches the centre tap.
      do_reset();
      send(-16'sd32768, 1'b0, "", 0);
      for (int k = 0; k < 6; k++) send(16'sd0, 1'b0, "", 0);
      send(16'sd0, 1'b1, "R7 clamp to 0x8000", -32768);

      // R1: reset with a loaded history; a zero sample must give zero.
      do_reset();
      send(16'sd0, 1'b1, "R1 history cleared by reset", 0);
      idle(0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule